// File: doc/BRIEF.md
# Endian-Converting Register Port Controller

This block sits between the execution pipeline and a general-purpose register file whose storage always holds 64-bit words in little-endian byte order. A single mode bit selects the data byte order that software sees. When the bit selects big-endian, every value crossing the read or write port is byte-reversed over the full 64 bits. When it selects little-endian, the ports pass data through unchanged. The storage itself never has to be rewritten when the mode changes.

A change of the mode bit is serialised. The controller asks the pipeline to drain completely and holds a stall until the drain is reported done. It then flips the bit in a single cycle and releases the stall. While the stall is high, register accesses from the pipeline are dropped, so no access can observe a half-switched mode. A requester that meets the busy indication keeps its request asserted, and the request is taken once the controller is idle again.

A combinational conversion helper serves moves between general registers and the program counter or special registers, which are always held little-endian. In big-endian mode it reverses bytes inside lanes of the operand size. In little-endian mode it passes the value through.

Top module: `endian_regport`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, modeBig is 0 (little-endian), and stall, modeBusy, flushReq and rdValid are 0.
- R2: With modeBig=0, a read returns rfRdData unchanged on rdData with rdValid=1 in the same cycle. A write presents wrData unchanged on rfWrData with rfWrEn=1. Both addresses pass through unchanged.
- R3: With modeBig=1, byte i (bits 8i+7:8i) of rdData equals byte 7-i of rfRdData. Byte i of rfWrData equals byte 7-i of wrData.
- R4: A request (modeReqValid=1 while modeBusy=0) is accepted at the next clock edge. In the following cycle flushReq, stall and modeBusy are 1. flushReq is high for exactly one cycle.
- R5: After the flush request, stall stays high for as long as flushDone stays low. On the first edge with flushDone=1, the block enters a cycle in which stall is still 1 and modeBig still has its old value. At the next edge, modeBig takes the requested value (modeReqBig: 1 = big-endian) and stall falls in the same cycle. modeBusy falls one cycle later.
- R6: modeBig changes at no other time. A flushDone pulse while no mode change is in progress has no effect on modeBig, stall or modeBusy.
- R7: A request made while modeBusy=1 is not accepted and raises no flushReq. If it is held, it is accepted at the first edge with modeBusy=0, and a new flush sequence follows.
- R8: While stall=1, rfWrEn, rfRdEn and rdValid are 0 and rdData is 0, whatever rdEn and wrEn are. A write issued during stall leaves the stored word unchanged.
- R9: The transfer helper treats xferSize as a lane width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. With modeBig=1, xferOut reverses the byte order inside each lane of xferIn. With modeBig=0, xferOut equals xferIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeReqValid | input | 1 | Request to set the data byte order |
| modeReqBig | input | 1 | Requested order: 1 = big-endian, 0 = little-endian |
| modeBusy | output | 1 | A mode change is in progress; requests are not taken |
| flushReq | output | 1 | One-cycle request for a full pipeline drain |
| flushDone | input | 1 | Pipeline reports the drain complete |
| stall | output | 1 | Pipeline hold during the mode change |
| modeBig | output | 1 | Current data byte order, 1 = big-endian |
| rdEn | input | 1 | Pipeline read request |
| rdAddr | input | ADDR_W | Pipeline read register index |
| rdValid | output | 1 | Read accepted; rdData is valid |
| rdData | output | DATA_W | Read value in the current byte order |
| rfRdEn | output | 1 | Read enable to storage |
| rfRdAddr | output | ADDR_W | Read index to storage |
| rfRdData | input | DATA_W | Little-endian word from storage |
| wrEn | input | 1 | Pipeline write request |
| wrAddr | input | ADDR_W | Pipeline write register index |
| wrData | input | DATA_W | Write value in the current byte order |
| rfWrEn | output | 1 | Write enable to storage |
| rfWrAddr | output | ADDR_W | Write index to storage |
| rfWrData | output | DATA_W | Little-endian word to storage |
| xferSize | input | 2 | Lane width code for the transfer helper |
| xferIn | input | DATA_W | Value moving between a general and a special register |
| xferOut | output | DATA_W | Converted transfer value |

## Verification
The port conversions and the transfer helper are combinational, so the bench drives them just after a falling edge and compares them a time step later, before the next rising edge. In the mode sequence, each state lasts one cycle from the edge that enters it. flushReq and stall are due one edge after the request is taken. The flip cycle follows one edge after flushDone is sampled. The new modeBig value and the fall of stall are due on the edge after that, and modeBusy falls one further edge later. The bench steps edge by edge and samples each of these at the falling edge of the cycle in which it is due. It also checks the cycles before that, to confirm that nothing changes early.

// File: rtl/endian_regport_pkg.sv
package endian_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FLUSH_REQ = 3'd1,
    ST_WAIT_DONE = 3'd2,
    ST_FLIP      = 3'd3,
    ST_RESUME    = 3'd4
  } modeState_t;

  typedef struct packed {
    logic stall;
    logic bigMode;
  } portStrobe_t;

endpackage

// File: rtl/endian_regport_ctrl.sv
module endian_regport_ctrl
  import endian_regport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        modeReqValid,
  input  logic        modeReqBig,
  input  logic        flushDone,
  output logic        modeBusy,
  output logic        flushReq,
  output portStrobe_t strobe
);

  modeState_t stateQ, stateD;
  logic       modeBigQ;
  logic       targetQ;
  logic       accept;
  logic       stallInt;

  assign accept   = (stateQ == ST_IDLE) && modeReqValid;
  assign modeBusy = (stateQ != ST_IDLE);
  assign flushReq = (stateQ == ST_FLUSH_REQ);
  assign stallInt = (stateQ == ST_FLUSH_REQ) || (stateQ == ST_WAIT_DONE) ||
                    (stateQ == ST_FLIP);

  assign strobe.stall   = stallInt;
  assign strobe.bigMode = modeBigQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:      if (modeReqValid) stateD = ST_FLUSH_REQ;
      ST_FLUSH_REQ: stateD = ST_WAIT_DONE;
      ST_WAIT_DONE: if (flushDone) stateD = ST_FLIP;
      ST_FLIP:      stateD = ST_RESUME;
      ST_RESUME:    stateD = ST_IDLE;
      default:      stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      modeBigQ <= 1'b0;
      targetQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) targetQ <= modeReqBig;
      if (stateQ == ST_FLIP) modeBigQ <= targetQ;
    end
  end

  // R4: an accepted request raises the flush and the stall on the next cycle
  a_r4_flush_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReqValid && !modeBusy) |=> (flushReq && stallInt));

  // R4: the flush request lasts one cycle
  a_r4_flush_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |=> !flushReq);

  // R5: the stall is held while the drain is not yet reported
  a_r5_stall_held_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_WAIT_DONE && !flushDone) |=> stallInt);

  // R5: the stall falls only when leaving the flip cycle
  a_r5_release_after_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stallInt) |-> $past(stateQ == ST_FLIP));

  // R6: the mode bit moves only out of the flip cycle
  a_r6_mode_only_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ != ST_FLIP) |=> $stable(modeBigQ));

  // R7: no new flush starts while a change is in progress
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    modeBusy |=> !flushReq);

endmodule

// File: rtl/endian_regport_dp.sv
module endian_regport_dp
  import endian_regport_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 5,
  parameter int SZ_W   = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  portStrobe_t       strobe,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rfRdEn,
  output logic [ADDR_W-1:0] rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  input  logic [SZ_W-1:0]   xferSize,
  input  logic [DATA_W-1:0] xferIn,
  output logic [DATA_W-1:0] xferOut
);

  localparam int BYTES    = DATA_W / 8;
  localparam int SIZE_CNT = $clog2(BYTES) + 1;
  localparam int LAST_B   = BYTES - 1;

  logic [DATA_W-1:0] rdSwapped;
  logic [DATA_W-1:0] wrSwapped;
  logic [DATA_W-1:0] xferBySize [SIZE_CNT];

  // full-word byte reversal for both storage ports
  for (genvar b = 0; b < BYTES; b++) begin : g_word_swap
    assign rdSwapped[8*b +: 8] = rfRdData[8*(LAST_B-b) +: 8];
    assign wrSwapped[8*b +: 8] = wrData[8*(LAST_B-b) +: 8];
  end

  // lane-wise byte reversal, one variant per operand size
  for (genvar s = 0; s < SIZE_CNT; s++) begin : g_size
    localparam int LANE = 1 << s;
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      localparam int SRC = (b / LANE) * LANE + (LANE - 1) - (b % LANE);
      assign xferBySize[s][8*b +: 8] = xferIn[8*SRC +: 8];
    end
  end

  assign rfRdEn   = rdEn && !strobe.stall;
  assign rfRdAddr = rdAddr;
  assign rdValid  = rfRdEn;
  assign rdData   = !rfRdEn ? '0 : (strobe.bigMode ? rdSwapped : rfRdData);

  assign rfWrEn   = wrEn && !strobe.stall;
  assign rfWrAddr = wrAddr;
  assign rfWrData = strobe.bigMode ? wrSwapped : wrData;

  assign xferOut  = strobe.bigMode ? xferBySize[xferSize] : xferIn;

  // R8: storage sees no write while the pipeline is held
  a_r8_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stall |-> !rfWrEn);

  // R8: a held pipeline gets no read data
  a_r8_no_read_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stall |-> (!rdValid && rdData == '0));

  // R3: in big-endian mode the lowest read byte comes from the top stored byte
  a_r3_be_read_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && strobe.bigMode) |-> rdData[7:0] == rfRdData[DATA_W-1 -: 8]);

  // R2: in little-endian mode a write reaches storage unchanged
  a_r2_le_write_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rfWrEn && !strobe.bigMode) |-> rfWrData == wrData);

endmodule

// File: rtl/endian_regport.sv
module endian_regport
  import endian_regport_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeReqValid,
  input  logic              modeReqBig,
  output logic              modeBusy,
  output logic              flushReq,
  input  logic              flushDone,
  output logic              stall,
  output logic              modeBig,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rfRdEn,
  output logic [ADDR_W-1:0] rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  input  logic [1:0]        xferSize,
  input  logic [DATA_W-1:0] xferIn,
  output logic [DATA_W-1:0] xferOut
);

  portStrobe_t strobe;

  assign stall   = strobe.stall;
  assign modeBig = strobe.bigMode;

  endian_regport_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .modeReqValid (modeReqValid),
    .modeReqBig   (modeReqBig),
    .flushDone    (flushDone),
    .modeBusy     (modeBusy),
    .flushReq     (flushReq),
    .strobe       (strobe)
  );

  endian_regport_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SZ_W   (2)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rfRdEn   (rfRdEn),
    .rfRdAddr (rfRdAddr),
    .rfRdData (rfRdData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rfWrEn   (rfWrEn),
    .rfWrAddr (rfWrAddr),
    .rfWrData (rfWrData),
    .xferSize (xferSize),
    .xferIn   (xferIn),
    .xferOut  (xferOut)
  );

endmodule

// File: tb/test_endian_regport.sv
module test_endian_regport;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          modeReqValid = 1'b0, modeReqBig = 1'b0, flushDone = 1'b0;
  logic          modeBusy, flushReq, stall, modeBig;
  logic          rdEn = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] rdAddr = '0, wrAddr = '0;
  logic          rdValid, rfRdEn, rfWrEn;
  logic [DW-1:0] rdData, rfRdData, wrData = '0, rfWrData, xferIn = '0, xferOut;
  logic [AW-1:0] rfRdAddr, rfWrAddr;
  logic [1:0]    xferSize = '0;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] store [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (rfWrEn) store[rfWrAddr] <= rfWrData;
  assign rfRdData = store[rfRdAddr];

  endian_regport i_endian_regport (.*);

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] laneRev(logic [DW-1:0] v, int lane);
    logic [DW-1:0] r;
    for (int i = 0; i < DW/8; i++) begin
      int base = (i / lane) * lane;
      int off  = i - base;
      r[8*i +: 8] = v[8*(base + lane - 1 - off) +: 8];
    end
    return r;
  endfunction

  task automatic nextCycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    nextCycle();
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [AW-1:0] a, string what, logic [DW-1:0] exp);
    rdEn = 1'b1; rdAddr = a;
    #1;
    chk({what, " rdValid"}, {63'd0, rdValid}, 64'd1);
    chk(what, rdData, exp);
    rdEn = 1'b0;
  endtask

  task automatic tReset();
    #1;
    chk("R1 modeBig in reset", {63'd0, modeBig}, 64'd0);
    chk("R1 stall in reset", {63'd0, stall}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nextCycle();
    chk("R1 modeBig", {63'd0, modeBig}, 64'd0);
    chk("R1 stall/busy/flush", {61'd0, stall, modeBusy, flushReq}, 64'd0);
    chk("R1 rdValid", {63'd0, rdValid}, 64'd0);
  endtask

  task automatic tLePass();
    doWrite(5'd3, 64'h0102030405060708);
    chk("R2 stored LE word", store[3], 64'h0102030405060708);
    doRead(5'd3, "R2 LE read", 64'h0102030405060708);
    wrEn = 1'b1; wrAddr = 5'd9; wrData = 64'hA1B2C3D4E5F60718; #1;
    chk("R2 LE write port", rfWrData, 64'hA1B2C3D4E5F60718);
    chk("R2 write address", {59'd0, rfWrAddr}, 64'd9);
    wrEn = 1'b0;
  endtask

  // full mode change; a write and read are tried during the flip cycle (R8)
  task automatic tModeChange(logic big, int waitCycles);
    logic oldMode = modeBig;
    chk("R4 busy before request", {63'd0, modeBusy}, 64'd0);
    modeReqValid = 1'b1; modeReqBig = big;
    nextCycle();
    modeReqValid = 1'b0;
    chk("R4 flushReq/stall/busy", {61'd0, flushReq, stall, modeBusy}, 64'd7);
    chk("R5 mode unchanged at flush", {63'd0, modeBig}, {63'd0, oldMode});
    nextCycle();
    chk("R4 flushReq one cycle", {63'd0, flushReq}, 64'd0);
    for (int i = 0; i < waitCycles; i++) begin
      chk("R5 stall while waiting", {63'd0, stall}, 64'd1);
      nextCycle();
    end
    flushDone = 1'b1;
    nextCycle();
    flushDone = 1'b0;
    chk("R5 stall in flip", {63'd0, stall}, 64'd1);
    chk("R5 mode old in flip", {63'd0, modeBig}, {63'd0, oldMode});
    wrEn = 1'b1; wrAddr = 5'd3; wrData = 64'hDEADBEEFDEADBEEF;
    rdEn = 1'b1; rdAddr = 5'd3; #1;
    chk("R8 rfWrEn stalled", {63'd0, rfWrEn}, 64'd0);
    chk("R8 rfRdEn/rdValid stalled", {62'd0, rfRdEn, rdValid}, 64'd0);
    chk("R8 rdData stalled", rdData, 64'd0);
    nextCycle();
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R5 new mode", {63'd0, modeBig}, {63'd0, big});
    chk("R5 stall released", {63'd0, stall}, 64'd0);
    chk("R5 busy in resume", {63'd0, modeBusy}, 64'd1);
    nextCycle();
    chk("R5 busy cleared", {63'd0, modeBusy}, 64'd0);
  endtask

  task automatic tBeAccess();
    chk("R8 stalled write dropped", store[3], 64'h0102030405060708);
    doRead(5'd3, "R3 BE read of LE word", 64'h0807060504030201);
    doWrite(5'd7, 64'h1122334455667788);
    chk("R3 stored BE write", store[7], 64'h8877665544332211);
    doRead(5'd7, "R3 BE read back", 64'h1122334455667788);
  endtask

  task automatic tStrayDone();
    logic m = modeBig;
    flushDone = 1'b1;
    nextCycle();
    flushDone = 1'b0;
    nextCycle();
    chk("R6 stray done mode", {63'd0, modeBig}, {63'd0, m});
    chk("R6 stray done stall/busy", {62'd0, stall, modeBusy}, 64'd0);
  endtask

  task automatic tBusyHold();
    modeReqValid = 1'b1; modeReqBig = 1'b1;
    nextCycle();
    modeReqBig = 1'b0;
    nextCycle();
    for (int i = 0; i < 2; i++) begin
      chk("R7 no flush while busy", {63'd0, flushReq}, 64'd0);
      nextCycle();
    end
    flushDone = 1'b1;
    nextCycle();
    flushDone = 1'b0;
    nextCycle();
    chk("R7 first change done", {63'd0, modeBig}, 64'd1);
    chk("R7 no flush in resume", {63'd0, flushReq}, 64'd0);
    nextCycle();
    chk("R7 idle before retake", {63'd0, modeBusy}, 64'd0);
    nextCycle();
    modeReqValid = 1'b0;
    chk("R7 held request taken", {63'd0, flushReq}, 64'd1);
    nextCycle();
    flushDone = 1'b1;
    nextCycle();
    flushDone = 1'b0;
    nextCycle();
    chk("R7 second change applied", {63'd0, modeBig}, 64'd0);
    nextCycle();
  endtask

  task automatic tXfer(logic big);
    xferIn = 64'h0011223344556677;
    for (int s = 0; s < 4; s++) begin
      xferSize = s[1:0]; #1;
      chk($sformatf("R9 xfer size %0d mode %0d", s, big), xferOut,
          big ? laneRev(xferIn, 1 << s) : xferIn);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) store[i] = '0;
    @(negedge clk);
    tReset();
    tLePass();
    tXfer(1'b0);
    tStrayDone();
    tModeChange(1'b1, 3);
    tBeAccess();
    tXfer(1'b1);
    tStrayDone();
    tModeChange(1'b0, 0);
    doRead(5'd7, "R2 LE read of stored word", 64'h8877665544332211);
    tBusyHold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule